// File: doc/BRIEF.md
# Frame Alignment Offset Meter

This block measures how far an external frame-evaluation signal lags the local frame pulse, counted in master-clock cycles. Software arms a measurement by setting a start bit. The block then waits for the next reference frame edge and counts from there to the matching edge of the evaluation input. It publishes the count, together with a completion flag, when the following reference frame edge arrives.

The compared edge polarity follows the frame-pulse convention in use:

- With the mode input low, both signals are active low and their falling edges are compared.
- With the mode input high, both are active high and their rising edges are compared.

To measure again, software first clears the start bit. Clearing it drops the completion flag and leaves the last published offset readable.

Top module: `frame_align_meter`

## Requirements
- R1: After reset, `done_o` is 0 and `offset_o` is 0.
- R2: A measurement arms on the first clock with `start_i` high while idle. The next reference frame edge opens the window, and `done_o` rises one cycle after the second reference frame edge is detected.
- R3: The offset is the number of clock cycles from the opening reference edge to the first evaluation edge after it, and 0 when both edges fall in the same cycle. Each edge is recognised in exactly one cycle.
- R4: With `rise_mode_i` = 0, falling edges (1 to 0) of `frame_i` and `eval_i` are the compared edges; rising edges are ignored.
- R5: With `rise_mode_i` = 1, rising edges (0 to 1) of `frame_i` and `eval_i` are the compared edges; falling edges are ignored.
- R6: The offset counter is 12 bits wide and saturates at 4095 instead of wrapping.
- R7: If no evaluation edge occurs before the closing reference edge, the published offset is the window length in cycles, saturated at 4095.
- R8: One cycle after `start_i` is seen low, `done_o` is 0, and `offset_o` keeps its value.
- R9: While a measurement runs, or after one is aborted by clearing `start_i`, `done_o` is 0 and `offset_o` keeps the previous result. `offset_o` changes only in the cycle `done_o` rises.
- R10: While `start_i` stays high after completion, no new measurement starts. Further frame and evaluation edges leave `done_o` at 1 and `offset_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Local reference frame pulse |
| eval_i | input | 1 | Frame-evaluation input to be measured |
| start_i | input | 1 | Start-evaluation control bit |
| rise_mode_i | input | 1 | 0: falling edges compared, 1: rising edges compared |
| done_o | output | 1 | Completion flag, a valid offset is readable |
| offset_o | output | 12 | Measured offset in clock cycles |

## Verification
A wrong state in the sequencer shows at the ports as `done_o` rising one frame early or late, or never. The bench checks the flag in the last cycle before the closing frame edge and in the cycle after it. A counter that starts one cycle off, or an edge detector with the wrong polarity, shifts the published offset by one. A polarity error shows because each evaluation pulse lasts one cycle, so its two edges are one count apart. Any premature copy of the running count into the result register changes `offset_o` before `done_o` rises, and the bench catches it within the window by comparing against the previous result.

// File: rtl/frame_align_pkg.sv
package frame_align_pkg;
  localparam int unsigned OFS_W = 12;
  localparam int unsigned N_SIG = 2;  // 0: frame, 1: eval

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_COUNT,
    ST_TAIL,
    ST_DONE
  } meas_state_e;
endpackage

// File: rtl/fa_edge_sel.sv
module fa_edge_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign edge_o = rise_sel_i ? (sig_i & ~sig_q) : (~sig_i & sig_q);

  // an edge is seen in one cycle only, unless the polarity is switched
  assert_edge_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (!edge_o || !$stable(rise_sel_i)));
endmodule

// File: rtl/fa_sat_cnt.sv
module fa_sat_cnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CntMax = {W{1'b1}};
  localparam logic [W-1:0] CntOne = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= CntOne;
    else if (inc_i && cnt_q != CntMax) cnt_q <= cnt_q + CntOne;
  end

  assign cnt_o = cnt_q;

  assert_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CntMax && !load_i) |=> cnt_q == CntMax);
endmodule

// File: rtl/fa_ctrl.sv
module fa_ctrl
  import frame_align_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         ref_edge_i,
  input  logic         cmp_edge_i,
  input  logic [W-1:0] cnt_i,
  output logic         load_o,
  output logic         inc_o,
  output logic         done_o,
  output logic [W-1:0] offset_o
);
  meas_state_e state_q;
  logic [W-1:0] meas_q;    // captured count, published at completion
  logic [W-1:0] offset_q;
  logic         done_q;

  assign load_o = (state_q == ST_ARM) && ref_edge_i;
  assign inc_o  = (state_q == ST_COUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      meas_q   <= '0;
      offset_q <= '0;
      done_q   <= 1'b0;
    end else if (!start_i) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: state_q <= ST_ARM;
        ST_ARM: if (ref_edge_i) begin
          if (cmp_edge_i) begin
            meas_q  <= '0;
            state_q <= ST_TAIL;
          end else begin
            state_q <= ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (ref_edge_i) begin
            offset_q <= cnt_i;
            done_q   <= 1'b1;
            state_q  <= ST_DONE;
          end else if (cmp_edge_i) begin
            meas_q  <= cnt_i;
            state_q <= ST_TAIL;
          end
        end
        ST_TAIL: if (ref_edge_i) begin
          offset_q <= meas_q;
          done_q   <= 1'b1;
          state_q  <= ST_DONE;
        end
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign offset_o = offset_q;

  assert_clear_drops_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  assert_offset_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(offset_o) |-> $rose(done_o));
  assert_done_on_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(ref_edge_i));
endmodule

// File: rtl/frame_align_meter.sv
module frame_align_meter
  import frame_align_pkg::*;
#(
  parameter int unsigned W = OFS_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frame_i,
  input  logic         eval_i,
  input  logic         start_i,
  input  logic         rise_mode_i,
  output logic         done_o,
  output logic [W-1:0] offset_o
);
  logic [N_SIG-1:0] raw;
  logic [N_SIG-1:0] edg;
  logic [W-1:0]     cnt;
  logic             load;
  logic             inc;

  assign raw = {eval_i, frame_i};

  for (genvar g = 0; g < N_SIG; g++) begin : g_det
    fa_edge_sel u_det (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sig_i      (raw[g]),
      .rise_sel_i (rise_mode_i),
      .edge_o     (edg[g])
    );
  end

  fa_sat_cnt #(.W(W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .inc_i  (inc),
    .cnt_o  (cnt)
  );

  fa_ctrl #(.W(W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ref_edge_i (edg[0]),
    .cmp_edge_i (edg[1]),
    .cnt_i      (cnt),
    .load_o     (load),
    .inc_o      (inc),
    .done_o     (done_o),
    .offset_o   (offset_o)
  );
endmodule

// File: tb/frame_align_meter_test.sv
module frame_align_meter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_i = 1'b1;
  logic        eval_i = 1'b1;
  logic        start_i = 1'b0;
  logic        rise_mode_i = 1'b0;
  logic        done_o;
  logic [11:0] offset_o;

  int n_tests = 0;
  int n_fail  = 0;
  int prev_off = 0;

  frame_align_meter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .eval_i(eval_i),
    .start_i(start_i), .rise_mode_i(rise_mode_i), .done_o(done_o), .offset_o(offset_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_off(input int per, input int dly, input bit ev_en);
    int v;
    v = ev_en ? dly : per;
    return (v > 4095) ? 4095 : v;
  endfunction

  // drive one cycle at the falling clock edge, sample 1 ns after the rising edge
  task automatic step(input bit fr_act, input bit ev_act);
    @(negedge clk_i);
    frame_i = rise_mode_i ? fr_act : ~fr_act;
    eval_i  = rise_mode_i ? ev_act : ~ev_act;
    @(posedge clk_i);
    #1;
  endtask

  task automatic go_idle(input bit md);
    @(negedge clk_i);
    start_i = 1'b0;
    rise_mode_i = md;
    frame_i = ~md;
    eval_i  = ~md;
    repeat (3) step(1'b0, 1'b0);
  endtask

  // start at c=0, opening frame edge at c=3, closing edge at c=3+per
  task automatic run_meas(input int per, input int dly, input bit md, input bit ev_en,
                          input string tag);
    int exp_off;
    exp_off = expect_off(per, dly, ev_en);
    go_idle(md);
    @(negedge clk_i);
    start_i = 1'b1;
    for (int c = 0; c <= 3 + per; c++) begin
      step(c >= 3 && ((c - 3) % per) == 0, ev_en && c == 3 + dly);
      if (c == 2 + per) begin
        check(done_o == 1'b0, {tag, " R9 done low in window"}, int'(done_o), 0);
        check(int'(offset_o) == prev_off, {tag, " R9 previous offset kept"},
              int'(offset_o), prev_off);
      end
    end
    check(done_o == 1'b1, {tag, " R2 done after closing frame edge"}, int'(done_o), 1);
    check(int'(offset_o) == exp_off, {tag, " R3 offset"}, int'(offset_o), exp_off);
    prev_off = int'(offset_o);
  endtask

  task automatic clear_start(input string tag);
    @(negedge clk_i);
    start_i = 1'b0;
    @(posedge clk_i);
    #1;
    check(done_o == 1'b0, {tag, " R8 done cleared"}, int'(done_o), 0);
    check(int'(offset_o) == prev_off, {tag, " R8 offset held"}, int'(offset_o), prev_off);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk_i);
    #1;
    check(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    check(offset_o == 12'd0, "R1 reset offset", int'(offset_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed cases
    run_meas(40, 0, 1'b0, 1'b1, "R4 same-cycle falling");
    clear_start("a");
    run_meas(40, 0, 1'b1, 1'b1, "R5 same-cycle rising");
    clear_start("b");
    run_meas(64, 17, 1'b0, 1'b1, "R4 falling d17");
    clear_start("c");
    run_meas(64, 17, 1'b1, 1'b1, "R5 rising d17");
    clear_start("d");
    run_meas(50, 49, 1'b0, 1'b1, "R3 last cycle");
    clear_start("e");
    run_meas(90, 0, 1'b1, 1'b0, "R7 no eval short");
    clear_start("f");
    run_meas(4300, 0, 1'b0, 1'b0, "R7 no eval long");
    clear_start("g");
    run_meas(4600, 4400, 1'b1, 1'b1, "R6 saturated");
    clear_start("h");

    // R10: start held high after completion, more edges arrive
    run_meas(30, 9, 1'b0, 1'b1, "R10 setup");
    for (int c = 0; c < 70; c++) step((c % 30) == 0, (c % 30) == 4);
    check(done_o == 1'b1, "R10 done stays high", int'(done_o), 1);
    check(int'(offset_o) == prev_off, "R10 offset unchanged", int'(offset_o), prev_off);
    clear_start("i");

    // R9: abort mid-window, then frames keep running
    go_idle(1'b1);
    @(negedge clk_i);
    start_i = 1'b1;
    for (int c = 0; c < 10; c++) step(c == 3, 1'b0);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 80; c++) step((c % 25) == 0, (c % 25) == 6);
    check(done_o == 1'b0, "R9 abort done low", int'(done_o), 0);
    check(int'(offset_o) == prev_off, "R9 abort offset kept", int'(offset_o), prev_off);

    // random measurements
    for (int i = 0; i < 12; i++) begin
      int per;
      int dly;
      bit md;
      bit en;
      per = 20 + int'($urandom % 180);
      dly = int'($urandom % per);
      md  = 1'($urandom % 2);
      en  = ($urandom % 4) != 0;
      run_meas(per, dly, md, en, md ? "R5 random" : "R4 random");
      clear_start("rnd");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule